// File: doc/BRIEF.md
# Flash Instruction Fetch Buffer

This block sits between a synchronous flash array and the instruction fetch port of a small two-stage core. It accepts AHB-Lite read transfers, holds the most recently fetched flash data in a line buffer and returns whole 32-bit words, each carrying two 16-bit instructions. The line is one word wide (two instructions) while the cache mode input is low. It is two words wide (four instructions) while the mode input is high. A fetch that falls inside the held line completes with no wait state. Any other fetch stalls the bus and refills the line from flash.

Two fault hooks support robustness testing of software and of the core. A freeze input blocks the line contents from being overwritten during a refill, while the buffer still records the new line as held. Later fetches therefore replay the old group of instructions. A flip mask XORs chosen bits of the held line on their way out, which corrupts instructions. A stored even-parity bit per halfword lets the buffer flag corruption that changes an odd number of bits in a halfword.

The flash array is modelled inside the block. It returns one 32-bit word per fixed latency, and its contents are computed from the address.

Top module: `fib_fetch_buffer`

## Requirements
- R1: After reset, `hready_o` is 1 and `par_err_o` is 0, and no line is valid, so the first fetch misses.
- R2: A transfer is accepted on a clock edge where `htrans_i` is NONSEQ (2'b10) or SEQ (2'b11) and `hready_o` is 1. Its data is returned in a later cycle, the first one in which `hready_o` is 1, and the data phase address is held while `hready_o` is 0.
- R3: With `cache_en_i` = 0 the line holds the single 32-bit word at byte address `haddr_i[15:2]*4`. Fetches of either halfword of that word hit, and a fetch from any other word misses.
- R4: With `cache_en_i` = 1 the line holds the two words of the 8-byte-aligned group that contains the address. A fetch of any of its four halfwords hits, in any order.
- R5: Flash returns one word every FLASH_LAT (default 2) cycles. A miss therefore holds `hready_o` low for FLASH_LAT*W+1 data phase cycles, where W is 1 or 2 words per line: 3 cycles with caching off and 5 with caching on.
- R6: A hit completes in its first data phase cycle, with zero wait states, and starts no flash access.
- R7: The flash halfword at halfword index h (byte address 2h) holds h XOR 16'hC3A5. `hrdata_o` returns the full word, with the lower-addressed halfword in bits [15:0] and the higher one in bits [31:16].
- R8: While `freeze_i` is 1 during a refill, the stall length is unchanged but the held data is not replaced. Fetches in the new line return the previously held word at the same slot.
- R9: `hrdata_o` equals the held word XOR `flip_mask_i[32*s+31:32*s]`. The slot s is 0 with caching off; with caching on, s is `haddr_i[2]`.
- R10: `par_err_o` is 1 in the completing data phase cycle exactly when a delivered halfword has an odd number of bits flipped by the mask. An even number of flips in a halfword goes unflagged.
- R11: A change of `cache_en_i` invalidates the line, so the next fetch misses even at an address that hit before.
- R12: `hready_o` stays 0 for as long as a line refill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| haddr_i | input | ADDR_W | Byte address of the fetch (address phase) |
| htrans_i | input | 2 | AHB transfer type; NONSEQ or SEQ requests a fetch |
| hready_o | output | 1 | Transfer completes / next address accepted when 1 |
| hrdata_o | output | 32 | Read data, two instructions, little-endian halfwords |
| par_err_o | output | 1 | Parity mismatch on the delivered word, valid with data |
| cache_en_i | input | 1 | Line width: 0 = one word, 1 = two words |
| freeze_i | input | 1 | Fault hook: block line data update during refill |
| flip_mask_i | input | 64 | Fault hook: XOR mask over the held line, word 0 in [31:0] |

## Verification
Sequential streams in both modes tell a hit from a miss by counting wait states, and they prove that the line width follows the mode. Out-of-order fetches inside a 64-bit line show that hits do not depend on order. Repeating a fetch of the same address after a mode change separates invalidation from a plain tag compare. Holding freeze during a refill into a known previous line distinguishes replayed data from new flash data. Masks with odd and even bit counts, placed in one slot and then the other, separate data corruption from parity flagging and show which slot each mask word affects.

// File: rtl/fib_pkg.sv
// Shared constants, types and the flash content function for the fetch buffer.
// Assumes 16-bit instructions packed two to a 32-bit flash word.
package fib_pkg;
    localparam int HW_W      = 16;
    localparam int WORD_W    = 32;
    localparam int SLOTS     = 2;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int LINE_BITS = SLOTS * WORD_W;

    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    typedef enum logic {FILL_IDLE, FILL_BUSY} fill_state_t;

    // Content of the flash halfword at a given halfword index.
    function automatic logic [HW_W-1:0] flash_half(input logic [31:0] hidx);
        return hidx[HW_W-1:0] ^ 16'hC3A5;
    endfunction

    // Content of the flash word at a given word index, low halfword first.
    function automatic logic [WORD_W-1:0] flash_word(input logic [31:0] widx);
        return {flash_half({widx[30:0], 1'b1}), flash_half({widx[30:0], 1'b0})};
    endfunction
endpackage

// File: rtl/fib_flash_model.sv
// Synchronous flash array model with a fixed read latency.
// A request pulse latches a word address; the word is presented with
// rvalid_o LAT cycles later. A new request may be issued in the rvalid cycle.
module fib_flash_model
    import fib_pkg::*;
#(
    parameter int WADDR_W = 14,
    parameter int LAT     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [WADDR_W-1:0] waddr_i,
    output logic               rvalid_o,
    output logic [WORD_W-1:0]  rdata_o
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic               busy_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [WADDR_W-1:0] addr_q;

    // Track the outstanding read and count down its latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (req_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LAT - 1);
            addr_q <= waddr_i;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign rvalid_o = busy_q && (cnt_q == '0);
    assign rdata_o  = flash_word(32'(addr_q));

    // R5
    // req_overlap_chk
    req_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> (!busy_q || rvalid_o));
endmodule

// File: rtl/fib_line_store.sv
// Line buffer storage: SLOTS words plus one even-parity bit per halfword.
// Parity is computed from the clean flash data at write time. The read path
// applies the fault flip mask and recomputes parity on the delivered word.
module fib_line_store
    import fib_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [SLOT_W-1:0]    wr_slot_i,
    input  logic [WORD_W-1:0]    wr_data_i,
    input  logic [SLOT_W-1:0]    rd_slot_i,
    input  logic [LINE_BITS-1:0] flip_mask_i,
    output logic [WORD_W-1:0]    rd_data_o,
    output logic                 par_bad_o
);
    localparam int HALVES = WORD_W / HW_W;

    logic [WORD_W-1:0] data_q [SLOTS];
    logic [HALVES-1:0] par_q  [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Store one word and its per-halfword parity when its slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[s] <= '0;
                par_q[s]  <= '0;
            end else if (wr_en_i && (wr_slot_i == SLOT_W'(s))) begin
                data_q[s] <= wr_data_i;
                for (int h = 0; h < HALVES; h++)
                    par_q[s][h] <= ^wr_data_i[h*HW_W +: HW_W];
            end
        end
    end

    logic [WORD_W-1:0] mask_word;
    logic [HALVES-1:0] par_now;

    // Select the requested word, corrupt it by the mask, and check parity.
    always_comb begin
        mask_word = flip_mask_i[rd_slot_i*WORD_W +: WORD_W];
        rd_data_o = data_q[rd_slot_i] ^ mask_word;
        for (int h = 0; h < HALVES; h++)
            par_now[h] = ^rd_data_o[h*HW_W +: HW_W];
        par_bad_o = (par_now != par_q[rd_slot_i]);
    end

    // R10
    // clean_parity_chk
    clean_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_mask_i == '0) |-> !par_bad_o);
endmodule

// File: rtl/fib_fill_ctrl.sv
// Line refill sequencer. On start it reads NWORDS consecutive words from
// flash, starting at the line base, and writes each one into its slot
// unless freeze is high when that word arrives. Pulses done_o with the last word.
module fib_fill_ctrl
    import fib_pkg::*;
#(
    parameter int WADDR_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WADDR_W-1:0] base_i,
    input  logic [SLOT_W:0]    nwords_i,
    input  logic               freeze_i,
    input  logic               rvalid_i,
    output logic               req_o,
    output logic [WADDR_W-1:0] req_waddr_o,
    output logic               wr_en_o,
    output logic [SLOT_W-1:0]  wr_slot_o,
    output logic               done_o,
    output logic               busy_o
);
    fill_state_t        state_q;
    logic [WADDR_W-1:0] base_q;
    logic [SLOT_W-1:0]  idx_q;
    logic [SLOT_W:0]    nwords_q;
    logic               last;

    assign last = (({1'b0, idx_q} + (SLOT_W+1)'(1)) == nwords_q);

    // Decode flash requests, line writes and completion from the state.
    always_comb begin
        busy_o      = (state_q == FILL_BUSY);
        req_o       = 1'b0;
        req_waddr_o = base_i;
        wr_en_o     = 1'b0;
        wr_slot_o   = idx_q;
        done_o      = 1'b0;
        if (state_q == FILL_IDLE) begin
            req_o = start_i;
        end else if (rvalid_i) begin
            wr_en_o     = !freeze_i;
            done_o      = last;
            req_o       = !last;
            req_waddr_o = base_q + WADDR_W'(idx_q) + WADDR_W'(1);
        end
    end

    // Advance through the words of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FILL_IDLE;
            base_q   <= '0;
            idx_q    <= '0;
            nwords_q <= '0;
        end else if (state_q == FILL_IDLE) begin
            if (start_i) begin
                state_q  <= FILL_BUSY;
                base_q   <= base_i;
                idx_q    <= '0;
                nwords_q <= nwords_i;
            end
        end else if (rvalid_i) begin
            if (last) state_q <= FILL_IDLE;
            else      idx_q   <= idx_q + 1'b1;
        end
    end

    // R5
    // rvalid_unexpected_chk
    rvalid_unexpected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_i |-> busy_o);
endmodule

// File: rtl/fib_fetch_buffer.sv
// Flash instruction fetch buffer with AHB-Lite read port.
// Holds one line (1 or 2 words by cache_en_i) and serves hits with zero
// wait states; misses stall hready_o while the line refills from flash.
// Fault hooks: freeze_i blocks line data updates (replay), flip_mask_i
// corrupts delivered bits (flagged by parity when PARITY_EN).
// Assumes halfword-aligned fetches and a read-only bus master.
module fib_fetch_buffer
    import fib_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int FLASH_LAT = 2,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    haddr_i,
    input  logic [1:0]           htrans_i,
    output logic                 hready_o,
    output logic [WORD_W-1:0]    hrdata_o,
    output logic                 par_err_o,
    input  logic                 cache_en_i,
    input  logic                 freeze_i,
    input  logic [LINE_BITS-1:0] flip_mask_i
);
    localparam int WADDR_W = ADDR_W - 2;

    logic               dp_active_q;
    logic [ADDR_W-2:0]  dp_haddr_q;
    logic               cache_q;
    logic               line_valid_q;
    logic [WADDR_W-1:0] tag_q;

    logic               addr_ph, hit, start, mode_chg;
    logic [WADDR_W-1:0] dp_waddr, line_base;
    logic [SLOT_W-1:0]  rd_slot;
    logic [SLOT_W:0]    nwords;

    logic               fl_req, fl_rvalid;
    logic [WADDR_W-1:0] fl_waddr;
    logic [WORD_W-1:0]  fl_rdata;
    logic               wr_en, fill_done, fill_busy;
    logic [SLOT_W-1:0]  wr_slot;
    logic               par_bad;

    // Hit detection, stall and refill start for the current data phase.
    always_comb begin
        addr_ph   = ((htrans_i == TR_NONSEQ) || (htrans_i == TR_SEQ)) && hready_o;
        dp_waddr  = dp_haddr_q[ADDR_W-2:1];
        line_base = cache_q ? {dp_waddr[WADDR_W-1:1], 1'b0} : dp_waddr;
        rd_slot   = cache_q ? SLOT_W'(dp_waddr[0]) : '0;
        nwords    = cache_q ? (SLOT_W+1)'(2) : (SLOT_W+1)'(1);
        mode_chg  = (cache_en_i != cache_q);
        hit       = line_valid_q && !mode_chg && (tag_q == line_base);
        start     = dp_active_q && !hit && !fill_busy && !mode_chg;
    end

    assign hready_o = !dp_active_q || (hit && !fill_busy);

    // Register the address phase into the data phase when the bus advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_active_q <= 1'b0;
            dp_haddr_q  <= '0;
        end else if (hready_o) begin
            dp_active_q <= addr_ph;
            if (addr_ph) dp_haddr_q <= haddr_i[ADDR_W-1:1];
        end
    end

    // Line bookkeeping: mode tracking, tag and valid state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_q      <= 1'b0;
            line_valid_q <= 1'b0;
            tag_q        <= '0;
        end else if (mode_chg && !fill_busy) begin
            cache_q      <= cache_en_i;
            line_valid_q <= 1'b0;
        end else if (start) begin
            tag_q        <= line_base;
            line_valid_q <= 1'b0;
        end else if (fill_done) begin
            line_valid_q <= 1'b1;
        end
    end

    fib_flash_model #(.WADDR_W(WADDR_W), .LAT(FLASH_LAT)) u_flash (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (fl_req),
        .waddr_i  (fl_waddr),
        .rvalid_o (fl_rvalid),
        .rdata_o  (fl_rdata)
    );

    fib_fill_ctrl #(.WADDR_W(WADDR_W)) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .base_i      (line_base),
        .nwords_i    (nwords),
        .freeze_i    (freeze_i),
        .rvalid_i    (fl_rvalid),
        .req_o       (fl_req),
        .req_waddr_o (fl_waddr),
        .wr_en_o     (wr_en),
        .wr_slot_o   (wr_slot),
        .done_o      (fill_done),
        .busy_o      (fill_busy)
    );

    fib_line_store u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_slot_i   (wr_slot),
        .wr_data_i   (fl_rdata),
        .rd_slot_i   (rd_slot),
        .flip_mask_i (flip_mask_i),
        .rd_data_o   (hrdata_o),
        .par_bad_o   (par_bad)
    );

    if (PARITY_EN) begin : g_par
        assign par_err_o = dp_active_q && hready_o && par_bad;
    end else begin : g_nopar
        assign par_err_o = 1'b0;
    end

    // R12
    // fill_stall_chk
    fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> !hready_o);

    // R6
    // hit_no_flash_chk
    hit_no_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_active_q && hit) |-> !fl_req);

    // R2
    // dphase_hold_chk
    dphase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_active_q && !hready_o) |=> (dp_active_q && $stable(dp_haddr_q)));

    // R2
    // halfword_align_chk
    halfword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ph |-> (haddr_i[0] == 1'b0));

    // R11
    // mode_change_stall_chk
    mode_change_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_active_q && mode_chg) |-> !hready_o);

    // R10
    // perr_with_data_chk
    perr_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> (dp_active_q && hready_o));
endmodule

// File: tb/tb_fib_fetch_buffer.sv
// Scoreboard bench: fetch() predicts each transfer from the requirements and
// queues it; a monitor completes data phases and compares data, parity flag
// and wait-state count.
module tb_fib_fetch_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hready;
    logic [31:0] hrdata;
    logic        perr;
    logic        cache_en = 1'b0;
    logic        freeze = 1'b0;
    logic [63:0] mask = '0;

    always #4 clk = ~clk;

    fib_fetch_buffer dut (
        .clk(clk), .rst_n(rst_n), .haddr_i(haddr), .htrans_i(htrans),
        .hready_o(hready), .hrdata_o(hrdata), .par_err_o(perr),
        .cache_en_i(cache_en), .freeze_i(freeze), .flip_mask_i(mask)
    );

    typedef struct {
        logic [31:0] data;
        logic        perr;
        int          waits;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic        m_valid = 1'b0;
    logic        m_mode = 1'b0;
    logic [13:0] m_tag = '0;
    logic [31:0] m_line [2];

    function automatic logic [15:0] hw(input int h);
        return 16'(h) ^ 16'hC3A5;
    endfunction

    function automatic logic [31:0] fword(input int w);
        return {hw(2*w + 1), hw(2*w)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Predict and issue one fetch.
    task automatic fetch(input logic [15:0] a, input string req);
        int w, base, slot;
        bit hit;
        exp_t e;
        logic [31:0] mk;
        w    = int'(a) >> 2;
        base = m_mode ? (w & ~1) : w;
        slot = m_mode ? (w & 1) : 0;
        hit  = m_valid && (m_tag == 14'(base));
        e.waits = hit ? 0 : (m_mode ? 5 : 3);
        if (!hit) begin
            m_valid = 1'b1;
            m_tag   = 14'(base);
            if (!freeze)
                for (int k = 0; k < (m_mode ? 2 : 1); k++) m_line[k] = fword(base + k);
        end
        mk = mask[slot*32 +: 32];
        e.data = m_line[slot] ^ mk;
        e.perr = (^mk[15:0]) | (^mk[31:16]);
        e.req  = req;
        sbq.push_back(e);
        @(posedge clk); #1;
        haddr  = a;
        htrans = 2'b10;
        do @(negedge clk); while (!hready);
    endtask

    task automatic drain();
        @(posedge clk); #1;
        htrans = 2'b00;
        while (sbq.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic set_mode(input logic m);
        drain();
        cache_en = m;
        m_mode   = m;
        m_valid  = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // Monitor: count waits, compare at data phase completion.
    initial begin
        bit dp;
        int waits;
        exp_t e;
        dp = 0;
        waits = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                dp = 0;
                waits = 0;
            end else begin
                if (dp) begin
                    if (!hready) waits++;
                    else begin
                        if (sbq.size() == 0) begin
                            check(1'b0, "R2", "unexpected data phase", hrdata, '0);
                        end else begin
                            e = sbq.pop_front();
                            check(hrdata == e.data, e.req, "data", hrdata, e.data);
                            check(perr == e.perr, e.req, "parity flag", 32'(perr), 32'(e.perr));
                            check(waits == e.waits, e.req, "wait states", waits, e.waits);
                        end
                        waits = 0;
                        dp = 0;
                    end
                end
                if (htrans[1] && hready) dp = 1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hready == 1'b1, "R1", "hready after reset", 32'(hready), 1);
        check(perr == 1'b0, "R1", "par_err after reset", 32'(perr), 0);

        // R3 / R7 / R5: caching off, one-word line
        fetch(16'h0000, "R1");
        fetch(16'h0002, "R3");
        fetch(16'h0004, "R7");
        fetch(16'h0006, "R6");
        fetch(16'h0000, "R3");
        for (int i = 0; i < 24; i++) fetch(16'(16'h0200 + 2*i), "R5");
        drain();

        // R4: caching on, two-word line, in and out of order
        set_mode(1'b1);
        fetch(16'h0010, "R4");
        fetch(16'h0012, "R4");
        fetch(16'h0014, "R4");
        fetch(16'h0016, "R6");
        fetch(16'h001E, "R4");
        fetch(16'h0018, "R4");
        fetch(16'h001A, "R4");
        for (int i = 0; i < 24; i++) fetch(16'(16'h0400 + 2*i), "R5");
        fetch(16'h0018, "R4");
        fetch(16'h001C, "R4");
        drain();

        // R8: freeze during a refill replays the old line
        freeze = 1'b1;
        fetch(16'h0040, "R8");
        fetch(16'h0046, "R8");
        fetch(16'h0042, "R8");
        drain();
        freeze = 1'b0;
        fetch(16'h0048, "R8");
        fetch(16'h004C, "R8");
        drain();

        // R9 / R10: flip mask corruption and parity
        mask = 64'h0000_0000_0001_0000;
        fetch(16'h0048, "R10");
        drain();
        mask = 64'h0000_0000_0000_0003;
        fetch(16'h004A, "R10");
        drain();
        mask = 64'h0100_0000_0000_0000;
        fetch(16'h0048, "R9");
        fetch(16'h004C, "R9");
        drain();
        mask = 64'h0000_0000_8000_0001;
        fetch(16'h004E, "R9");
        fetch(16'h0048, "R10");
        drain();
        mask = '0;

        // R11: mode change invalidates
        fetch(16'h0048, "R6");
        set_mode(1'b0);
        fetch(16'h0048, "R11");
        fetch(16'h004A, "R11");
        set_mode(1'b1);
        fetch(16'h0048, "R11");

        // R8 with caching off
        set_mode(1'b0);
        fetch(16'h0100, "R3");
        drain();
        freeze = 1'b1;
        fetch(16'h0104, "R8");
        drain();
        freeze = 1'b0;
        fetch(16'h0108, "R12");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule